// File: doc/BRIEF.md
# RMII Receive/Transmit Adapter

This block sits between a nibble-wide physical-layer data path and a two-bit reduced media-independent interface that runs on a single 50 MHz reference clock. On the receive side it takes a stream of nibbles, each with an error flag, together with a carrier indication. It sends them out as pairs of bits on `rmii_rxd`, with a combined carrier-sense/data-valid line (`rmii_crs_dv`) and a receive error line. A small FIFO holds nibbles that are still in flight when carrier drops. The adapter keeps draining them and marks the drain phase by pulsing the combined line on the second pair of every nibble.

On the transmit side it samples `rmii_txd` while `rmii_tx_en` is high. It pairs consecutive samples into nibbles and presents each finished nibble with a one-cycle strobe. A speed input selects 100 Mbps, where each pair lasts one reference clock cycle, or 10 Mbps, where each pair lasts ten cycles. Everything runs on the one reference clock. The nibble producer is expected to be synchronous to it.

Top module: `rmii_adapter`

## Requirements
- R1: When `phy_rx_carrier` is sampled high while the receiver is idle, `rmii_crs_dv` rises in the next cycle on the first pair slot of a nibble. Slots for which no nibble is buffered carry `rmii_rxd` = 00 (an all-zero filler nibble). For a nibble written in the same cycle that carrier is first seen, exactly one filler nibble precedes the data.
- R2: `rmii_crs_dv` only falls right after the second pair slot of a nibble, never between the two pairs of one nibble.
- R3: After carrier is lost, every nibble still buffered is sent with `rmii_crs_dv` low on its first pair and high on its second pair. After the last one, the line stays low.
- R4: Within a nibble, bits [1:0] are sent in the first slot and bits [3:2] in the second. Nibbles leave in arrival order, with none lost or added.
- R5: With `speed_100` = 0, every receive slot (pair value, `rmii_crs_dv` and `rmii_rx_er`) holds for 10 consecutive cycles, and filler slots carry 00 ahead of the first data pair.
- R6: `rmii_rx_er` is high on both slots of a nibble that arrived with `phy_rx_err` set, is low on the slots of other nibbles, and is low whenever the receiver is idle.
- R7: While `rmii_tx_en` is low, `rmii_txd` is ignored, and no nibble strobe is produced from it.
- R8: With `speed_100` = 1, every cycle with `rmii_tx_en` high supplies one pair, low pair first. `phy_tx_valid` pulses for one cycle, in the cycle after the edge that sampled a nibble's second pair, with `phy_tx_nibble` = {second pair, first pair}.
- R9: With `speed_100` = 0, each pair spans 10 cycles counted from the first cycle of `rmii_tx_en` high (index 0). It is sampled only at index 4 within its span, and the strobe follows the second pair's sample edge by one cycle.
- R10: If `rmii_tx_en` falls after an odd number of pairs, the half nibble is discarded and the next burst starts again with a low pair.
- R11: Out of reset, `rmii_crs_dv`, `rmii_rxd`, `rmii_rx_er` and `phy_tx_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 selects 100 Mbps, 0 selects 10 Mbps |
| phy_rx_carrier | input | 1 | Receive carrier present |
| phy_rx_valid | input | 1 | One-cycle strobe writing `phy_rx_nibble` into the receive FIFO |
| phy_rx_nibble | input | 4 | Received nibble |
| phy_rx_err | input | 1 | Error flag for the nibble being written |
| rmii_crs_dv | output | 1 | Combined carrier sense and data valid |
| rmii_rxd | output | 2 | Receive pair |
| rmii_rx_er | output | 1 | Receive error for the current pair |
| rmii_tx_en | input | 1 | Transmit enable |
| rmii_txd | input | 2 | Transmit pair |
| phy_tx_valid | output | 1 | One-cycle strobe for a completed transmit nibble |
| phy_tx_nibble | output | 4 | Completed transmit nibble |

## Verification
The bench targets the end of a receive frame. A design that dropped `rmii_crs_dv` as soon as carrier vanished would lose the buffered nibbles. One that let it fall between the two pairs of a nibble would cut a nibble in half. A burst of back-to-back nibbles forces three drained nibbles, so a pulse placed on the wrong pair, or pulsing that stops early, shows up in the captured slot pattern. At 10 Mbps the receive slots are checked cycle by cycle for stability. The transmit data is made correct only at sample index 4 of each span, so a design that samples at any other point collects inverted bits. A burst that stops after an odd number of pairs exposes an assembler that keeps a stale half nibble and misaligns the following burst. The placement of the error flag, the pair order and the filler 00 slots are all compared with values worked out independently.

// File: rtl/rmii_adapter_pkg.sv
package rmii_adapter_pkg;
    localparam int NIBBLE_W = 4;
    localparam int PAIR_W   = 2;

    typedef struct packed {
        logic [NIBBLE_W-1:0] data;
        logic                err;
    } rx_nib_t;
endpackage

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo
    import rmii_adapter_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr_en,
    input  rx_nib_t wr_data,
    input  logic    rd_en,
    output rx_nib_t rd_data,
    output logic    empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t    p_d, p_q;
    rx_nib_t slot_q [DEPTH];
    logic    full, do_wr, do_rd;

    assign full    = (p_q.cnt == CW'(DEPTH));
    assign empty   = (p_q.cnt == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = slot_q[p_q.rp];

    always_comb begin
        p_d = p_q;
        if (do_wr) p_d.wp = (p_q.wp == AW'(DEPTH - 1)) ? '0 : p_q.wp + 1'b1;
        if (do_rd) p_d.rp = (p_q.rp == AW'(DEPTH - 1)) ? '0 : p_q.rp + 1'b1;
        p_d.cnt = p_q.cnt + CW'(do_wr) - CW'(do_rd);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_wr && p_q.wp == AW'(i)) slot_q[i] <= wr_data;
        end
    end
endmodule

// File: rtl/rmii_rx_serializer.sv
module rmii_rx_serializer
    import rmii_adapter_pkg::*;
#(
    parameter int REPEAT = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fast,
    input  logic        carrier,
    input  logic        fifo_empty,
    input  rx_nib_t     fifo_head,
    output logic        fifo_pop,
    output logic        crs_dv,
    output logic [1:0]  rxd,
    output logic        rx_er,
    output logic        active,
    output logic        phase
);
    localparam int REP_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;

    typedef struct packed {
        logic                active;
        logic                phase;
        logic [REP_W-1:0]    rep;
        logic [NIBBLE_W-1:0] cur;
        logic                cur_data;
        logic                crs;
        logic [PAIR_W-1:0]   rxd;
        logic                rxer;
    } ser_t;

    ser_t                s_d, s_q;
    logic                slot_end, load, have_nib;
    logic [NIBBLE_W-1:0] next_nib;

    always_comb begin
        s_d      = s_q;
        load     = 1'b0;
        fifo_pop = 1'b0;
        have_nib = !fifo_empty;
        next_nib = have_nib ? fifo_head.data : '0;
        slot_end = fast || (s_q.rep == REP_W'(REPEAT - 1));

        if (s_q.active && !fast) s_d.rep = slot_end ? '0 : s_q.rep + 1'b1;
        else                     s_d.rep = '0;

        if (!s_q.active) begin
            load = carrier;
        end else if (slot_end) begin
            if (!s_q.phase) begin
                s_d.phase = 1'b1;
                s_d.rxd   = s_q.cur[3:2];
                s_d.crs   = s_q.crs | s_q.cur_data;
            end else if (carrier || have_nib) begin
                load = 1'b1;
            end else begin
                s_d.active   = 1'b0;
                s_d.phase    = 1'b0;
                s_d.crs      = 1'b0;
                s_d.rxd      = '0;
                s_d.rxer     = 1'b0;
                s_d.cur      = '0;
                s_d.cur_data = 1'b0;
            end
        end

        if (load) begin
            s_d.active   = 1'b1;
            s_d.phase    = 1'b0;
            s_d.crs      = carrier;
            s_d.cur      = next_nib;
            s_d.cur_data = have_nib;
            s_d.rxer     = have_nib && fifo_head.err;
            s_d.rxd      = next_nib[1:0];
            fifo_pop     = have_nib;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign crs_dv = s_q.crs;
    assign rxd    = s_q.rxd;
    assign rx_er  = s_q.rxer;
    assign active = s_q.active;
    assign phase  = s_q.phase;
endmodule

// File: rtl/rmii_tx_assembler.sv
module rmii_tx_assembler
    import rmii_adapter_pkg::*;
#(
    parameter int REPEAT    = 10,
    parameter int SAMPLE_AT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fast,
    input  logic                tx_en,
    input  logic [PAIR_W-1:0]   txd,
    output logic                nib_valid,
    output logic [NIBBLE_W-1:0] nib_data
);
    localparam int REP_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;

    typedef struct packed {
        logic [REP_W-1:0]    rep;
        logic                phase;
        logic [PAIR_W-1:0]   low;
        logic [NIBBLE_W-1:0] nib;
        logic                vld;
    } asm_t;

    asm_t a_d, a_q;
    logic take;

    always_comb begin
        a_d     = a_q;
        a_d.vld = 1'b0;
        take    = 1'b0;
        if (!tx_en) begin
            a_d.rep   = '0;
            a_d.phase = 1'b0;
        end else begin
            take = fast || (a_q.rep == REP_W'(SAMPLE_AT));
            if (fast) a_d.rep = '0;
            else      a_d.rep = (a_q.rep == REP_W'(REPEAT - 1)) ? '0 : a_q.rep + 1'b1;
            if (take) begin
                if (!a_q.phase) begin
                    a_d.low   = txd;
                    a_d.phase = 1'b1;
                end else begin
                    a_d.nib   = {txd, a_q.low};
                    a_d.vld   = 1'b1;
                    a_d.phase = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign nib_valid = a_q.vld;
    assign nib_data  = a_q.nib;
endmodule

// File: rtl/rmii_adapter.sv
module rmii_adapter
    import rmii_adapter_pkg::*;
#(
    parameter int FIFO_DEPTH   = 4,
    parameter int SLOW_REPEAT  = 10,
    parameter int TX_SAMPLE_AT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       speed_100,
    input  logic       phy_rx_carrier,
    input  logic       phy_rx_valid,
    input  logic [3:0] phy_rx_nibble,
    input  logic       phy_rx_err,
    output logic       rmii_crs_dv,
    output logic [1:0] rmii_rxd,
    output logic       rmii_rx_er,
    input  logic       rmii_tx_en,
    input  logic [1:0] rmii_txd,
    output logic       phy_tx_valid,
    output logic [3:0] phy_tx_nibble
);
    rx_nib_t wr_nib, head_nib;
    logic    fifo_empty, fifo_pop;
    logic    rx_active, rx_phase;

    assign wr_nib = '{data: phy_rx_nibble, err: phy_rx_err};

    rmii_rx_fifo #(.DEPTH(FIFO_DEPTH)) i_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (phy_rx_valid),
        .wr_data (wr_nib),
        .rd_en   (fifo_pop),
        .rd_data (head_nib),
        .empty   (fifo_empty)
    );

    rmii_rx_serializer #(.REPEAT(SLOW_REPEAT)) i_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast       (speed_100),
        .carrier    (phy_rx_carrier),
        .fifo_empty (fifo_empty),
        .fifo_head  (head_nib),
        .fifo_pop   (fifo_pop),
        .crs_dv     (rmii_crs_dv),
        .rxd        (rmii_rxd),
        .rx_er      (rmii_rx_er),
        .active     (rx_active),
        .phase      (rx_phase)
    );

    rmii_tx_assembler #(.REPEAT(SLOW_REPEAT), .SAMPLE_AT(TX_SAMPLE_AT)) i_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast      (speed_100),
        .tx_en     (rmii_tx_en),
        .txd       (rmii_txd),
        .nib_valid (phy_tx_valid),
        .nib_data  (phy_tx_nibble)
    );
endmodule

// File: rtl/rmii_adapter_chk.sv
module rmii_adapter_chk #(
    parameter int SLOW_REPEAT = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       speed_100,
    input logic       rmii_crs_dv,
    input logic [1:0] rmii_rxd,
    input logic       rmii_rx_er,
    input logic       rx_active,
    input logic       rx_phase,
    input logic       rmii_tx_en,
    input logic       phy_tx_valid
);
    localparam int CW = (SLOW_REPEAT > 1) ? $clog2(SLOW_REPEAT) : 1;

    logic [CW-1:0] span_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !rx_active)              span_q <= '0;
        else if (span_q == CW'(SLOW_REPEAT-1)) span_q <= '0;
        else                                   span_q <= span_q + 1'b1;
    end

    AST_RISE_FIRST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_active) |-> rmii_crs_dv && !rx_phase); // R1

    AST_FALL_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rmii_crs_dv) |-> $past(rx_phase) && !rx_phase); // R2

    AST_SECOND_PAIR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active && rx_phase |-> rmii_crs_dv); // R3

    AST_SLOW_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active && $past(rx_active) && !speed_100 && !$past(speed_100) && span_q != '0
        |-> $stable(rmii_rxd) && $stable(rmii_crs_dv)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |-> !rmii_rx_er && !rmii_crs_dv && rmii_rxd == 2'b00); // R6

    AST_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        phy_tx_valid |-> $past(rmii_tx_en)); // R7
endmodule

bind rmii_adapter rmii_adapter_chk #(.SLOW_REPEAT(SLOW_REPEAT)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .speed_100    (speed_100),
    .rmii_crs_dv  (rmii_crs_dv),
    .rmii_rxd     (rmii_rxd),
    .rmii_rx_er   (rmii_rx_er),
    .rx_active    (rx_active),
    .rx_phase     (rx_phase),
    .rmii_tx_en   (rmii_tx_en),
    .phy_tx_valid (phy_tx_valid)
);

// File: tb/test_rmii_adapter.sv
module test_rmii_adapter;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n, speed_100;
    logic       car, vld, err;
    logic [3:0] nib;
    logic       rmii_crs_dv, rmii_rx_er, rmii_tx_en, phy_tx_valid;
    logic [1:0] rmii_rxd, rmii_txd;
    logic [3:0] phy_tx_nibble;

    rmii_adapter i_rmii_adapter (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100),
        .phy_rx_carrier(car), .phy_rx_valid(vld), .phy_rx_nibble(nib), .phy_rx_err(err),
        .rmii_crs_dv(rmii_crs_dv), .rmii_rxd(rmii_rxd), .rmii_rx_er(rmii_rx_er),
        .rmii_tx_en(rmii_tx_en), .rmii_txd(rmii_txd),
        .phy_tx_valid(phy_tx_valid), .phy_tx_nibble(phy_tx_nibble)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int         exp_nib [64];
    logic [1:0] txp     [64];
    logic       pc_a [64];
    logic       pc_b [64];
    logic       pe_a [64];
    logic       pe_b [64];
    logic [3:0] pd   [64];
    int         np;
    int         unst;
    logic [3:0] cap_nib [64];
    int         cap_cyc [64];
    int         ncap = 0;

    always @(negedge clk) begin
        if (rst_n === 1'b1 && phy_tx_valid === 1'b1 && ncap < 64) begin
            cap_nib[ncap] = phy_tx_nibble;
            cap_cyc[ncap] = cyc;
            ncap = ncap + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_nibs(input logic [63:0] v, input int n);
        for (int k = 0; k < n; k++) exp_nib[k] = int'(v[4*(n-1-k) +: 4]);
    endtask

    task automatic set_pairs(input logic [63:0] v, input int n);
        for (int j = 0; j < n; j++) txp[j] = v[2*(n-1-j) +: 2];
    endtask

    task automatic take_slot(input bit fast, output logic c, output logic [1:0] d, output logic e);
        c = rmii_crs_dv; d = rmii_rxd; e = rmii_rx_er;
        if (!fast) begin
            for (int r = 1; r < 10; r++) begin
                @(negedge clk);
                if (rmii_crs_dv !== c || rmii_rxd !== d || rmii_rx_er !== e) unst++;
            end
        end
        @(negedge clk);
    endtask

    task automatic run_rx(input bit fast, input int n, input int gap, input int err_idx,
                          input int exp_tog);
        int fill, tog, mid_fall, tail_bad;
        np = 0; unst = 0;
        fork
            begin
                @(negedge clk);
                car = 1'b1;
                for (int k = 0; k < n; k++) begin
                    vld = 1'b1; nib = exp_nib[k][3:0]; err = (k == err_idx);
                    @(negedge clk);
                    vld = 1'b0; err = 1'b0;
                    for (int g = 1; g < gap; g++) @(negedge clk);
                end
                car = 1'b0;
            end
            begin
                logic ca, cb, ea, eb;
                logic [1:0] da, db;
                while (rmii_crs_dv !== 1'b1) @(negedge clk);
                for (int s = 0; s < 60; s++) begin
                    take_slot(fast, ca, da, ea);
                    take_slot(fast, cb, db, eb);
                    if (!ca && !cb) break;
                    pc_a[np] = ca; pc_b[np] = cb; pe_a[np] = ea; pe_b[np] = eb;
                    pd[np] = {db, da};
                    np++;
                end
            end
        join
        fill = 0;
        while (fill < np && pd[fill] == 4'h0 && pc_a[fill] && pc_b[fill] && !pe_a[fill]) fill++;
        check(fill == 1, "R1 filler nibbles before data", fill, 1);
        check(np == fill + n, "R4 nibble count", np, fill + n);
        for (int k = 0; k < n && fill + k < np; k++) begin
            check(pd[fill+k] == exp_nib[k][3:0], "R4 nibble value", int'(pd[fill+k]), exp_nib[k]);
            check(pe_a[fill+k] == (k == err_idx) && pe_b[fill+k] == (k == err_idx),
                  "R6 error flag on nibble", int'(pe_a[fill+k]) + int'(pe_b[fill+k]),
                  (k == err_idx) ? 2 : 0);
        end
        mid_fall = 0; tog = 0; tail_bad = 0;
        for (int p = 0; p < np; p++) begin
            if (pc_a[p] && !pc_b[p]) mid_fall++;
            if (!pc_a[p] && pc_b[p]) tog++;
        end
        for (int p = np - tog; p < np; p++) if (p >= 0 && !(!pc_a[p] && pc_b[p])) tail_bad++;
        check(mid_fall == 0, "R2 fall inside a nibble", mid_fall, 0);
        check(tog == exp_tog, "R3 drained nibbles pulsed", tog, exp_tog);
        check(tail_bad == 0, "R3 pulsed nibbles at tail", tail_bad, 0);
        if (!fast) check(unst == 0, "R5 slot held ten cycles", unst, 0);
        check(rmii_rx_er == 1'b0 && rmii_crs_dv == 1'b0, "R6 idle after frame",
              int'(rmii_rx_er) + int'(rmii_crs_dv), 0);
        repeat (5) @(negedge clk);
    endtask

    task automatic run_tx(input bit fast, input int nd);
        int c0;
        int per;
        per = fast ? 1 : 10;
        ncap = 0;
        @(negedge clk);
        c0 = cyc;
        rmii_tx_en = 1'b1;
        for (int j = 0; j < nd; j++) begin
            for (int r = 0; r < per; r++) begin
                rmii_txd = (fast || r == 4) ? txp[j] : ~txp[j];
                @(negedge clk);
            end
        end
        rmii_tx_en = 1'b0;
        for (int r = 0; r < 25; r++) begin
            rmii_txd = 2'(r);
            @(negedge clk);
        end
        check(ncap == nd / 2, "R10 nibble count for burst", ncap, nd / 2);
        for (int k = 0; k < ncap && k < nd / 2; k++) begin
            check(cap_nib[k] == {txp[2*k+1], txp[2*k]}, fast ? "R8 tx nibble" : "R9 tx nibble",
                  int'(cap_nib[k]), int'({txp[2*k+1], txp[2*k]}));
            check(cap_cyc[k] == (fast ? c0 + 2*k + 2 : c0 + 20*k + 15),
                  fast ? "R8 tx strobe cycle" : "R9 tx strobe cycle", cap_cyc[k] - c0,
                  fast ? 2*k + 2 : 20*k + 15);
        end
    endtask

    task automatic tx_ignore();
        ncap = 0;
        rmii_tx_en = 1'b0;
        for (int r = 0; r < 30; r++) begin
            rmii_txd = 2'(r);
            @(negedge clk);
        end
        check(ncap == 0, "R7 txd ignored while enable low", ncap, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; speed_100 = 1'b1;
        car = 1'b0; vld = 1'b0; err = 1'b0; nib = 4'h0;
        rmii_tx_en = 1'b0; rmii_txd = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rmii_crs_dv == 1'b0, "R11 crs_dv after reset", int'(rmii_crs_dv), 0);
        check(rmii_rxd == 2'b00, "R11 rxd after reset", int'(rmii_rxd), 0);
        check(rmii_rx_er == 1'b0, "R11 rx_er after reset", int'(rmii_rx_er), 0);
        check(phy_tx_valid == 1'b0, "R11 tx strobe after reset", int'(phy_tx_valid), 0);

        set_nibs(64'h5555D3C09F, 10);
        run_rx(1'b1, 10, 2, -1, 1);
        set_nibs(64'h5D712, 5);
        run_rx(1'b1, 5, 2, 2, 1);
        set_nibs(64'h5A6B, 4);
        run_rx(1'b1, 4, 1, -1, 3);
        speed_100 = 1'b0;
        repeat (3) @(negedge clk);
        set_nibs(64'h55DE8, 5);
        run_rx(1'b0, 5, 20, 1, 1);

        speed_100 = 1'b1;
        tx_ignore();
        set_pairs(64'b01_10_11_00_10_01_00_11, 8);
        run_tx(1'b1, 8);
        set_pairs(64'b11_01_10, 3);
        run_tx(1'b1, 3);
        set_pairs(64'b10_11_00_01, 4);
        run_tx(1'b1, 4);
        speed_100 = 1'b0;
        tx_ignore();
        set_pairs(64'b01_11_10_00_11_01, 6);
        run_tx(1'b0, 6);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule